// File: doc/BRIEF.md
# Inter-Core Mailbox RAM Router

This block holds six one-way mailbox memories that carry data between three processor cores: two peer cores on a shared A-side bus (called A1 and A2) and a third core (B) that uses its own address map. Each ordered pair of cores owns one mailbox. The core that sends through a mailbox may read and write it. The core that receives may only read it. The remaining core cannot reach it at all. Every mailbox is 32 bits wide and is split into two sub-blocks of `SUB_DEPTH` words each.

The A-side bus carries a requester bit that names the issuing core. Two of the A-side windows are shared. The outbound window always reaches the issuing core's own A-to-B mailbox. The inbound window always reaches the issuing core's own B-to-A mailbox. The same A-side address therefore lands in a different physical bank depending on which core sends the request. Core B sees all four mailboxes it touches as separate windows at addresses of its own.

The router checks access rights on every request. A write without write permission, or any access to a window that grants no rights, changes no memory. It raises a one-cycle error pulse on that port together with the response. A denied read returns zero. Each port is a single-cycle request interface, and read data arrives one cycle after the request.

Top module: `mbox_router`

## Requirements
- R1: A-side address layout is {window[1:0], sub, offset}. Window 0 is the A1-to-A2 mailbox and window 1 is the A2-to-A1 mailbox. The sender writes its mailbox, and the peer core reads back the written word. The requester bit `a_core` is 0 for A1 and 1 for A2.
- R2: A-side window 2 is shared. A write there goes to the A1-to-B mailbox when `a_core`=0 and to the A2-to-B mailbox when `a_core`=1. The sender can also read its own word back through window 2.
- R3: A-side window 3 is shared and read-only. A read there returns the B-to-A1 mailbox for `a_core`=0 and the B-to-A2 mailbox for `a_core`=1.
- R4: A write without write rights is ignored and gives `err`=1 in the response cycle. This covers A2 writing window 0, A1 writing window 1, any A-side write to window 3, and B writing its windows 0 or 1. A later read shows the old word.
- R5: B-side address layout is {window[2:0], sub, offset}. Windows 0 and 1 read the A1-to-B and A2-to-B mailboxes. Windows 2 and 3 read and write the B-to-A1 and B-to-A2 mailboxes. Windows 4 to 7 grant no access. A read there returns zero with `err`=1, and a write there changes nothing.
- R6: A read request gives `rvalid`=1 with data exactly one cycle later, for one cycle. A write request never gives `rvalid`.
- R7: If an A-side write and a B-side read hit the same word in the same cycle, the read returns the old word. The next read returns the new word.
- R8: The sub bit selects one of two independent sub-blocks. The same offset in sub-block 0 and sub-block 1 holds different words.
- R9: While reset is held and in the cycle after it, `rvalid`, `err` and `rdata` are zero on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | A-side request strobe |
| a_we | input | 1 | A-side write (1) or read (0) |
| a_core | input | 1 | A-side requester: 0 = A1, 1 = A2 |
| a_addr | input | clog2(SUB_DEPTH)+3 | A-side word address {window, sub, offset} |
| a_wdata | input | DATA_W | A-side write data |
| a_rvalid | output | 1 | A-side read response valid |
| a_rdata | output | DATA_W | A-side read data, zero when denied |
| a_err | output | 1 | A-side access-error pulse |
| b_req | input | 1 | B-side request strobe |
| b_we | input | 1 | B-side write (1) or read (0) |
| b_addr | input | clog2(SUB_DEPTH)+4 | B-side word address {window, sub, offset} |
| b_wdata | input | DATA_W | B-side write data |
| b_rvalid | output | 1 | B-side read response valid |
| b_rdata | output | DATA_W | B-side read data, zero when denied |
| b_err | output | 1 | B-side access-error pulse |

## Verification
A bank index steered by the wrong requester shows up on the very next read. The other core's mailbox, or the far side's view, returns a word that the requesting core never wrote. The bench writes different data through A1 and A2 at the same shared address so that such a swap cannot pass. A wrong permission decode appears in the response cycle, either as a missing or spurious error pulse or as nonzero data on a denied read. A write that leaked past the check appears on the next readback of the protected word. A wrong read-versus-write ordering inside a bank shows up in the single cycle where the A-side write and the B-side read collide.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int NBANK = 6;

  // Physical mailbox indices
  localparam logic [2:0] BK_A1_A2 = 3'd0;
  localparam logic [2:0] BK_A2_A1 = 3'd1;
  localparam logic [2:0] BK_A1_B  = 3'd2;
  localparam logic [2:0] BK_B_A1  = 3'd3;
  localparam logic [2:0] BK_A2_B  = 3'd4;
  localparam logic [2:0] BK_B_A2  = 3'd5;

  typedef struct packed {
    logic [2:0] bank;
    logic       ok;
  } route_t;

  // Which side owns the write port of a bank
  function automatic bit writer_is_b(int idx);
    return (idx == 3) || (idx == 5);
  endfunction

  function automatic route_t route_a(logic we, logic core, logic [1:0] win);
    route_t r;
    case (win)
      2'd0:    begin r.bank = BK_A1_A2; r.ok = !we || (core == 1'b0); end
      2'd1:    begin r.bank = BK_A2_A1; r.ok = !we || (core == 1'b1); end
      2'd2:    begin r.bank = core ? BK_A2_B : BK_A1_B; r.ok = 1'b1; end
      default: begin r.bank = core ? BK_B_A2 : BK_B_A1; r.ok = !we;  end
    endcase
    return r;
  endfunction

  function automatic route_t route_b(logic we, logic [2:0] win);
    route_t r;
    case (win)
      3'd0:    begin r.bank = BK_A1_B; r.ok = !we;  end
      3'd1:    begin r.bank = BK_A2_B; r.ok = !we;  end
      3'd2:    begin r.bank = BK_B_A1; r.ok = 1'b1; end
      3'd3:    begin r.bank = BK_B_A2; r.ok = 1'b1; end
      default: begin r.bank = BK_A1_A2; r.ok = 1'b0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int DW = 32,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] qa,
  output logic [DW-1:0] qb
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-before-write: reads see the word held before this edge
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    qa <= mem[ra_addr];
    qb <= mem[rb_addr];
  end
endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter bit SIDE_B = 1'b0
) (
  input  logic       we,
  input  logic       core,
  input  logic [2:0] win,
  output logic [2:0] bank,
  output logic       ok
);
  route_t r;

  generate
    if (SIDE_B) begin : g_bside
      always_comb r = route_b(we, win);
    end else begin : g_aside
      always_comb r = route_a(we, core, win[1:0]);
    end
  endgenerate

  assign bank = r.bank;
  assign ok   = r.ok;
endmodule

// File: rtl/mbox_port_resp.sv
module mbox_port_resp #(
  parameter int DW = 32,
  parameter int NB = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               we,
  input  logic [2:0]         bank,
  input  logic               ok,
  input  logic [NB-1:0][DW-1:0] q,
  output logic               rvalid,
  output logic [DW-1:0]      rdata,
  output logic               err
);
  logic [2:0] sel_q;
  logic       ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
      ok_q   <= 1'b0;
      sel_q  <= '0;
    end else begin
      rvalid <= req && !we;
      err    <= req && !ok;
      ok_q   <= ok;
      sel_q  <= bank;
    end
  end

  always_comb begin
    rdata = '0;
    if (rvalid && ok_q) rdata = q[sel_q];
  end
endmodule

// File: rtl/mbox_router.sv
module mbox_router
  import mbox_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SUB_DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          a_req,
  input  logic                          a_we,
  input  logic                          a_core,
  input  logic [$clog2(SUB_DEPTH)+2:0]  a_addr,
  input  logic [DATA_W-1:0]             a_wdata,
  output logic                          a_rvalid,
  output logic [DATA_W-1:0]             a_rdata,
  output logic                          a_err,
  input  logic                          b_req,
  input  logic                          b_we,
  input  logic [$clog2(SUB_DEPTH)+3:0]  b_addr,
  input  logic [DATA_W-1:0]             b_wdata,
  output logic                          b_rvalid,
  output logic [DATA_W-1:0]             b_rdata,
  output logic                          b_err
);
  localparam int OFS_W = $clog2(SUB_DEPTH);
  localparam int BK_AW = OFS_W + 1;
  localparam int A_AW  = BK_AW + 2;
  localparam int B_AW  = BK_AW + 3;

  logic [BK_AW-1:0] a_loc, b_loc;
  logic [2:0]       a_win, b_win;
  logic [2:0]       a_bank, b_bank;
  logic             a_ok, b_ok;

  assign a_loc = a_addr[BK_AW-1:0];
  assign b_loc = b_addr[BK_AW-1:0];
  assign a_win = {1'b0, a_addr[A_AW-1 -: 2]};
  assign b_win = b_addr[B_AW-1 -: 3];

  mbox_port_dec #(.SIDE_B(1'b0)) u_dec_a (
    .we(a_we), .core(a_core), .win(a_win), .bank(a_bank), .ok(a_ok)
  );

  mbox_port_dec #(.SIDE_B(1'b1)) u_dec_b (
    .we(b_we), .core(1'b0), .win(b_win), .bank(b_bank), .ok(b_ok)
  );

  logic [NBANK-1:0][DATA_W-1:0] qa, qb;

  generate
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
      logic             bk_we;
      logic [BK_AW-1:0] bk_waddr;
      logic [DATA_W-1:0] bk_wdata;

      if (writer_is_b(i)) begin : g_wb
        assign bk_we    = b_req && b_we && b_ok && (b_bank == 3'(i));
        assign bk_waddr = b_loc;
        assign bk_wdata = b_wdata;
      end else begin : g_wa
        assign bk_we    = a_req && a_we && a_ok && (a_bank == 3'(i));
        assign bk_waddr = a_loc;
        assign bk_wdata = a_wdata;
      end

      mbox_bank #(.DW(DATA_W), .AW(BK_AW)) u_bank (
        .clk(clk), .we(bk_we), .waddr(bk_waddr), .wdata(bk_wdata),
        .ra_addr(a_loc), .rb_addr(b_loc), .qa(qa[i]), .qb(qb[i])
      );
    end
  endgenerate

  mbox_port_resp #(.DW(DATA_W), .NB(NBANK)) u_resp_a (
    .clk(clk), .rst(rst), .req(a_req), .we(a_we), .bank(a_bank), .ok(a_ok),
    .q(qa), .rvalid(a_rvalid), .rdata(a_rdata), .err(a_err)
  );

  mbox_port_resp #(.DW(DATA_W), .NB(NBANK)) u_resp_b (
    .clk(clk), .rst(rst), .req(b_req), .we(b_we), .bank(b_bank), .ok(b_ok),
    .q(qb), .rvalid(b_rvalid), .rdata(b_rdata), .err(b_err)
  );
endmodule

// File: rtl/mbox_router_chk.sv
module mbox_router_chk #(
  parameter int DATA_W    = 32,
  parameter int SUB_DEPTH = 64
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          a_req,
  input logic                          a_we,
  input logic                          a_core,
  input logic [$clog2(SUB_DEPTH)+2:0]  a_addr,
  input logic                          a_rvalid,
  input logic [DATA_W-1:0]             a_rdata,
  input logic                          a_err,
  input logic                          b_req,
  input logic                          b_we,
  input logic [$clog2(SUB_DEPTH)+3:0]  b_addr,
  input logic                          b_rvalid,
  input logic [DATA_W-1:0]             b_rdata,
  input logic                          b_err
);
  localparam int A_AW = $clog2(SUB_DEPTH) + 3;
  localparam int B_AW = $clog2(SUB_DEPTH) + 4;

  logic [1:0] a_w;
  logic [2:0] b_w;
  assign a_w = a_addr[A_AW-1 -: 2];
  assign b_w = b_addr[B_AW-1 -: 3];

  // R6
  a_rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (a_req && !a_we) |=> a_rvalid);

  // R6
  b_wr_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (b_req && b_we) |=> !b_rvalid);

  // R4
  a_ro_window_chk: assert property (@(posedge clk) disable iff (rst)
    (a_req && a_we && a_w == 2'd3) |=> a_err);

  // R4
  a_peer_write_chk: assert property (@(posedge clk) disable iff (rst)
    (a_req && a_we && a_w == 2'd0 && a_core) |=> a_err);

  // R5
  b_no_rights_chk: assert property (@(posedge clk) disable iff (rst)
    (b_req && b_w[2]) |=> b_err);

  // R5
  denied_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (b_rvalid && b_err) |-> (b_rdata == '0));

  // R9
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!a_rvalid && !a_err && !b_rvalid && !b_err));
endmodule

bind mbox_router mbox_router_chk #(.DATA_W(DATA_W), .SUB_DEPTH(SUB_DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .a_req(a_req), .a_we(a_we), .a_core(a_core), .a_addr(a_addr),
  .a_rvalid(a_rvalid), .a_rdata(a_rdata), .a_err(a_err),
  .b_req(b_req), .b_we(b_we), .b_addr(b_addr),
  .b_rvalid(b_rvalid), .b_rdata(b_rdata), .b_err(b_err)
);

// File: tb/mbox_router_tb.sv
module mbox_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 32;
  localparam int SUB = 64;

  typedef struct packed {
    logic [3:0]  rq;
    logic        isb;
    logic        we;
    logic        core;
    logic [2:0]  win;
    logic        sub;
    logic [5:0]  off;
    logic [31:0] wd;
    logic        xerr;
    logic [31:0] xd;
  } vec_t;

  // rq, isb, we, core, win, sub, off, wdata, exp_err, exp_data
  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 6'd5, 32'h1111_1111, 1'b0, 32'h0},          // R1 A1 writes A1->A2
    '{4'd1, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 6'd5, 32'h0,         1'b0, 32'h1111_1111}, // R1 A2 reads it
    '{4'd4, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 6'd5, 32'hDEAD_0001, 1'b1, 32'h0},          // R4 receiver write
    '{4'd4, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd5, 32'h0,         1'b0, 32'h1111_1111}, // R4 unchanged
    '{4'd1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 6'd7, 32'h2222_2222, 1'b0, 32'h0},          // R1 A2 writes A2->A1
    '{4'd1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 6'd7, 32'h0,         1'b0, 32'h2222_2222}, // R1 A1 reads it
    '{4'd2, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 6'd3, 32'hA1A1_B000, 1'b0, 32'h0},          // R2 A1 shared out
    '{4'd2, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 6'd3, 32'hA2A2_B000, 1'b0, 32'h0},          // R2 A2 shared out
    '{4'd2, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 6'd3, 32'h0,         1'b0, 32'hA1A1_B000}, // R2 B sees A1 bank
    '{4'd2, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 6'd3, 32'h0,         1'b0, 32'hA2A2_B000}, // R2 B sees A2 bank
    '{4'd2, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 6'd3, 32'h0,         1'b0, 32'hA1A1_B000}, // R2 sender readback
    '{4'd3, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 6'd9, 32'hB0A1_0000, 1'b0, 32'h0},          // R3 B writes B->A1
    '{4'd3, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 6'd9, 32'hB0A2_0000, 1'b0, 32'h0},          // R3 B writes B->A2
    '{4'd3, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 6'd9, 32'h0,         1'b0, 32'hB0A1_0000}, // R3 A1 shared in
    '{4'd3, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 6'd9, 32'h0,         1'b0, 32'hB0A2_0000}, // R3 A2 shared in
    '{4'd4, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 6'd9, 32'hDEAD_0002, 1'b1, 32'h0},          // R4 write to inbound
    '{4'd4, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 6'd9, 32'h0,         1'b0, 32'hB0A1_0000}, // R4 unchanged
    '{4'd4, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 6'd3, 32'hDEAD_0003, 1'b1, 32'h0},          // R4 B writes A1->B
    '{4'd4, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 6'd3, 32'h0,         1'b0, 32'hA1A1_B000}, // R4 unchanged
    '{4'd5, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 6'd5, 32'h0,         1'b1, 32'h0},          // R5 denied read
    '{4'd5, 1'b1, 1'b1, 1'b0, 3'd5, 1'b1, 6'd7, 32'hDEAD_0004, 1'b1, 32'h0},          // R5 denied write
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 6'd7, 32'h0,         1'b0, 32'h2222_2222}, // R5 A2->A1 unchanged
    '{4'd5, 1'b1, 1'b0, 1'b0, 3'd7, 1'b0, 6'd0, 32'h0,         1'b1, 32'h0},          // R5 unmapped read
    '{4'd8, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 6'd5, 32'h3333_3333, 1'b0, 32'h0},          // R8 sub-block 1
    '{4'd8, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 6'd5, 32'h0,         1'b0, 32'h1111_1111}, // R8 sub 0 intact
    '{4'd8, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 6'd5, 32'h0,         1'b0, 32'h3333_3333}  // R8 sub 1
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          a_req = 1'b0, a_we = 1'b0, a_core = 1'b0;
  logic [8:0]    a_addr = '0;
  logic [DW-1:0] a_wdata = '0;
  logic          a_rvalid, a_err;
  logic [DW-1:0] a_rdata;
  logic          b_req = 1'b0, b_we = 1'b0;
  logic [9:0]    b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic          b_rvalid, b_err;
  logic [DW-1:0] b_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_router #(.DATA_W(DW), .SUB_DEPTH(SUB)) u_dut (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_core(a_core), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata), .a_err(a_err),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rvalid(b_rvalid), .b_rdata(b_rdata), .b_err(b_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(vec_t v, int idx);
    logic rv, er;
    logic [31:0] rd;
    string tag;
    @(negedge clk);
    if (v.isb) begin
      b_req = 1'b1; b_we = v.we; b_addr = {v.win, v.sub, v.off}; b_wdata = v.wd;
    end else begin
      a_req = 1'b1; a_we = v.we; a_core = v.core;
      a_addr = {v.win[1:0], v.sub, v.off}; a_wdata = v.wd;
    end
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
    rv = v.isb ? b_rvalid : a_rvalid;
    er = v.isb ? b_err    : a_err;
    rd = v.isb ? b_rdata  : a_rdata;
    tag = $sformatf("R%0d vec%0d", v.rq, idx);
    chk({tag, " err"}, 32'(er), 32'(v.xerr));
    chk({tag, " rvalid"}, 32'(rv), 32'(!v.we));
    if (!v.we) chk({tag, " rdata"}, rd, v.xd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs idle during reset
    chk("R9 a_rvalid in reset", 32'(a_rvalid), 0);
    chk("R9 b_err in reset", 32'(b_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 a_rvalid after reset", 32'(a_rvalid), 0);
    chk("R9 a_err after reset", 32'(a_err), 0);
    chk("R9 a_rdata after reset", a_rdata, 0);
    chk("R9 b_rvalid after reset", 32'(b_rvalid), 0);
    chk("R9 b_rdata after reset", b_rdata, 0);

    for (int i = 0; i < NV; i++) run_op(VEC[i], i);

    // R7: A1 writes shared out window while B reads the same word
    @(negedge clk);
    a_req = 1'b1; a_we = 1'b1; a_core = 1'b0; a_addr = {2'd2, 1'b0, 6'd3}; a_wdata = 32'h5555_5555;
    b_req = 1'b1; b_we = 1'b0; b_addr = {3'd0, 1'b0, 6'd3};
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
    chk("R7 collide read old", b_rdata, 32'hA1A1_B000);
    chk("R7 collide rvalid", 32'(b_rvalid), 1);
    chk("R6 write gives no a_rvalid", 32'(a_rvalid), 0);
    @(negedge clk);
    // R6: response lasts one cycle only
    chk("R6 rvalid single cycle", 32'(b_rvalid), 0);
    b_req = 1'b1; b_we = 1'b0; b_addr = {3'd0, 1'b0, 6'd3};
    @(negedge clk);
    b_req = 1'b0;
    chk("R7 next read new", b_rdata, 32'h5555_5555);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule